// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

This block collects sixteen active-low interrupt lines from board-level sources, records each request in a sticky flag bit, and folds the pending requests onto four active-high interrupt outputs for a CPU. Each output serves a fixed, unevenly sized subset of the sources. Sources 1 to 14 are sensed by level. Source 15 is a push-button line that is sensed on its falling edge, and source 0 has no source behind it.

Software reaches two 16-bit registers over a plain synchronous bus with a word address, a write strobe, write data and combinational read data. The block mask register holds one blocking bit per source (1 blocks, 0 passes). The request flag register reads back the latched requests and clears them by written zeros: a 0 in a bit position drops that flag and a 1 leaves it as it is. A typical bring-up writes 0x7FFE to the mask and 0x0000 to the flags.

The falling-edge source has a small two-state machine. In state `EDGE_ARMED` (line seen high) a low sample raises a one-cycle set pulse and takes transition *arm-to-spent* to `EDGE_SPENT`. In `EDGE_SPENT` (line still low) nothing is raised, and a high sample takes transition *spent-to-arm* back to `EDGE_ARMED`. Reset enters `EDGE_ARMED`.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFFFF, the flag register reads 0x0000 and all four outputs are 0.
- R2: A write at word address 0x4 stores all 16 data bits into the mask register, and a read at 0x4 returns them on the next cycle.
- R3: A read at word address 0xC returns the flags. A write there clears every flag whose data bit is 0 and keeps every flag whose data bit is 1, and it never sets a flag.
- R4: Sources 1 to 14 are active low and level sensed. The flag is set from the third rising clock edge after the line goes low, and while the line stays low a clear write does not drop it.
- R5: Source 15 sets its flag only on a high-to-low change of its line. Holding the line low after a clear does not set the flag again. An edge that arrives in the same cycle as a clear leaves the flag set.
- R6: Flag bit 0 never sets, whatever its input does.
- R7: A source is pending when its flag is 1 and its mask bit is 0. Output g is registered and is 1 one cycle after any pending source in its group: group 0 is 0x0028, group 1 is 0x0050, group 2 is 0x1C00 and group 3 is 0x6386 (bit i of the value stands for source i).
- R8: A mask bit of 1 keeps its source off the outputs, but the flag still latches. Clearing the mask bit later raises the output.
- R9: Source 15 belongs to no group, so its flag alone never raises an output.
- R10: Reads at any address other than 0x4 and 0xC return 0, and writes there change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 16 | Active-low interrupt lines, one per source |
| addr | input | 4 | Word address of the register access |
| we | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the current address |
| irq_out | output | 4 | Active-high grouped interrupt outputs |

## Verification
Each level source is pulled low on its own with nothing masked, so the output vector separates the four group encodings bit by bit. Two sources in the same group held low at once, followed by a write with ones in all but one position, separate clear-on-zero from clear-on-one and show that a level held low survives a clear. One masked source that is released later separates flag latching from output gating. On the edge source, a line held low after a clear and a fresh fall timed onto the clear cycle separate edge sensing from level sensing and show which wins on a collision.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;

    localparam int DEF_SRC_N  = 16;
    localparam int DEF_OUT_N  = 4;
    localparam int DEF_ADDR_W = 4;

    localparam logic [DEF_ADDR_W-1:0] DEF_MASK_ADDR = 4'h4;
    localparam logic [DEF_ADDR_W-1:0] DEF_FLAG_ADDR = 4'hC;

    localparam logic [DEF_SRC_N-1:0] DEF_MASK_RST  = 16'hFFFF;
    localparam logic [DEF_SRC_N-1:0] DEF_LEVEL_SEL = 16'h7FFE;
    localparam logic [DEF_SRC_N-1:0] DEF_EDGE_SEL  = 16'h8000;

    // entry [g] lists the sources that feed output g
    localparam logic [DEF_OUT_N-1:0][DEF_SRC_N-1:0] DEF_GROUP_SEL =
        {16'h6386, 16'h1C00, 16'h0050, 16'h0028};

    typedef enum logic [0:0] {
        EDGE_ARMED = 1'b0,
        EDGE_SPENT = 1'b1
    } edge_state_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int             W       = 16,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/irq_edge_fsm.sv
module irq_edge_fsm
    import irq_group_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    output logic fall
);

    edge_state_e state_q;
    edge_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EDGE_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: arm-to-spent on a low sample, spent-to-arm on a high one
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_ARMED: if (!line_n) state_d = EDGE_SPENT;
            EDGE_SPENT: if (line_n)  state_d = EDGE_ARMED;
            default:                 state_d = EDGE_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        fall = 1'b0;
        unique case (state_q)
            EDGE_ARMED: fall = !line_n;
            EDGE_SPENT: fall = 1'b0;
            default:    fall = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int           W         = 16,
    parameter logic [W-1:0] LEVEL_SEL = '0,
    parameter logic [W-1:0] EDGE_SEL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_n,
    input  logic         clr_we,
    input  logic [W-1:0] clr_keep,
    output logic [W-1:0] flag_q,
    output logic [W-1:0] set_vec
);

    for (genvar i = 0; i < W; i++) begin : g_src
        if (EDGE_SEL[i]) begin : g_edge
            irq_edge_fsm u_fsm (
                .clk    (clk),
                .rst_n  (rst_n),
                .line_n (sync_n[i]),
                .fall   (set_vec[i])
            );
        end else if (LEVEL_SEL[i]) begin : g_level
            assign set_vec[i] = ~sync_n[i];
        end else begin : g_none
            assign set_vec[i] = 1'b0;
        end

        if (EDGE_SEL[i] || LEVEL_SEL[i]) begin : g_flag
            logic bit_q;
            // a new request outranks a clear in the same cycle
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (set_vec[i]) begin
                    bit_q <= 1'b1;
                end else if (clr_we && !clr_keep[i]) begin
                    bit_q <= 1'b0;
                end
            end
            assign flag_q[i] = bit_q;
        end else begin : g_noflag
            logic unused_src;
            assign unused_src = sync_n[i] ^ clr_keep[i];
            assign flag_q[i]  = 1'b0;
        end
    end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile #(
    parameter int                W         = 16,
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 4'h4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'hC,
    parameter logic [W-1:0]      MASK_RST  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      flag_q,
    output logic [W-1:0]      mask_q,
    output logic [W-1:0]      rdata,
    output logic              flag_wr
);

    logic mask_hit;
    logic flag_hit;

    assign mask_hit = (addr == MASK_ADDR);
    assign flag_hit = (addr == FLAG_ADDR);
    assign flag_wr  = we && flag_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
        end else if (we && mask_hit) begin
            mask_q <= wdata;
        end
    end

    always_comb begin
        if (mask_hit) begin
            rdata = mask_q;
        end else if (flag_hit) begin
            rdata = flag_q;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/irq_group_out.sv
module irq_group_out #(
    parameter int                  W         = 16,
    parameter int                  N         = 4,
    parameter logic [N-1:0][W-1:0] GROUP_SEL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flag_q,
    input  logic [W-1:0] mask_q,
    output logic [N-1:0] irq_out
);

    logic [W-1:0] pend;
    assign pend = flag_q & ~mask_q;

    for (genvar g = 0; g < N; g++) begin : g_out
        logic out_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q <= 1'b0;
            end else begin
                out_q <= |(pend & GROUP_SEL[g]);
            end
        end
        assign irq_out[g] = out_q;
    end

endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
    import irq_group_pkg::*;
#(
    parameter int                          SRC_N     = DEF_SRC_N,
    parameter int                          OUT_N     = DEF_OUT_N,
    parameter int                          ADDR_W    = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0]           MASK_ADDR = DEF_MASK_ADDR,
    parameter logic [ADDR_W-1:0]           FLAG_ADDR = DEF_FLAG_ADDR,
    parameter logic [SRC_N-1:0]            MASK_RST  = DEF_MASK_RST,
    parameter logic [SRC_N-1:0]            LEVEL_SEL = DEF_LEVEL_SEL,
    parameter logic [SRC_N-1:0]            EDGE_SEL  = DEF_EDGE_SEL,
    parameter logic [OUT_N-1:0][SRC_N-1:0] GROUP_SEL = DEF_GROUP_SEL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  irq_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [SRC_N-1:0]  wdata,
    output logic [SRC_N-1:0]  rdata,
    output logic [OUT_N-1:0]  irq_out
);

    localparam logic [SRC_N-1:0] IDLE_LINES = '1;

    logic [SRC_N-1:0] sync_n;
    logic [SRC_N-1:0] flag_q;
    logic [SRC_N-1:0] set_vec;
    logic [SRC_N-1:0] mask_q;
    logic             flag_wr;

    irq_sync #(
        .W       (SRC_N),
        .RST_VAL (IDLE_LINES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_n),
        .q     (sync_n)
    );

    irq_flag_bank #(
        .W         (SRC_N),
        .LEVEL_SEL (LEVEL_SEL),
        .EDGE_SEL  (EDGE_SEL)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_n   (sync_n),
        .clr_we   (flag_wr),
        .clr_keep (wdata),
        .flag_q   (flag_q),
        .set_vec  (set_vec)
    );

    irq_regfile #(
        .W         (SRC_N),
        .ADDR_W    (ADDR_W),
        .MASK_ADDR (MASK_ADDR),
        .FLAG_ADDR (FLAG_ADDR),
        .MASK_RST  (MASK_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .flag_q  (flag_q),
        .mask_q  (mask_q),
        .rdata   (rdata),
        .flag_wr (flag_wr)
    );

    irq_group_out #(
        .W         (SRC_N),
        .N         (OUT_N),
        .GROUP_SEL (GROUP_SEL)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_q  (flag_q),
        .mask_q  (mask_q),
        .irq_out (irq_out)
    );

endmodule

module irq_group_ctrl_chk
    import irq_group_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  we,
    input logic [DEF_ADDR_W-1:0] addr,
    input logic [DEF_SRC_N-1:0]  wdata,
    input logic [DEF_SRC_N-1:0]  flags,
    input logic [DEF_SRC_N-1:0]  mask,
    input logic [DEF_SRC_N-1:0]  set_vec,
    input logic [DEF_OUT_N-1:0]  irq_out
);

    p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == DEF_MASK_ADDR) |=> (mask == $past(wdata)));

    p_clear_on_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == DEF_FLAG_ADDR) |=> ((flags & ~$past(wdata) & ~$past(set_vec)) == '0));

    p_flag_needs_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags) & ~$past(set_vec)) == '0));

    p_edge_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[DEF_SRC_N-1] |=> !set_vec[DEF_SRC_N-1]);

    p_bit0_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[0]);

    p_nmi_no_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~mask) == 16'h8000) |=> (irq_out == '0));

    for (genvar g = 0; g < DEF_OUT_N; g++) begin : g_grp
        p_out_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (|(flags & ~mask & DEF_GROUP_SEL[g])) |=> irq_out[g]);
        p_out_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(|(flags & ~mask & DEF_GROUP_SEL[g])) |=> !irq_out[g]);
    end

endmodule

bind irq_group_ctrl irq_group_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we),
    .addr    (addr),
    .wdata   (wdata),
    .flags   (flag_q),
    .mask    (mask_q),
    .set_vec (set_vec),
    .irq_out (irq_out)
);

// File: tb/irq_group_ctrl_bench.sv
module irq_group_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] G0 = 16'h0028;
    localparam logic [15:0] G1 = 16'h0050;
    localparam logic [15:0] G2 = 16'h1C00;
    localparam logic [15:0] G3 = 16'h6386;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_n = 16'hFFFF;
    logic [3:0]  addr = 4'h0;
    logic        we = 1'b0;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic [3:0]  irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference state
    logic [15:0] m_s1, m_s2, m_flags, m_mask, m_pend, m_set, m_nf;
    logic [3:0]  m_out, m_nout;
    logic        m_prev15;

    irq_group_ctrl u_irq_group_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_n   (irq_n),
        .addr    (addr),
        .we      (we),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_out (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 16'hFFFF; m_s2 = 16'hFFFF; m_flags = 16'h0;
            m_mask = 16'hFFFF; m_out = 4'h0; m_prev15 = 1'b1;
        end else begin
            m_pend = m_flags & ~m_mask;
            m_nout = {|(m_pend & G3), |(m_pend & G2), |(m_pend & G1), |(m_pend & G0)};
            m_set = ~m_s2 & 16'h7FFE;
            if (m_prev15 && !m_s2[15]) m_set[15] = 1'b1;
            m_nf = m_flags;
            if (we && addr == 4'hC) m_nf = m_nf & wdata;
            m_nf = m_nf | m_set;
            if (we && addr == 4'h4) m_mask = wdata;
            m_prev15 = m_s2[15];
            m_s2 = m_s1;
            m_s1 = irq_n;
            m_flags = m_nf;
            m_out = m_nout;
        end
    end

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] grp_of(int i);
        return {G3[i], G2[i], G1[i], G0[i]};
    endfunction

    // one clock: wait for the falling edge and compare against the model
    task automatic tick();
        logic [15:0] exp_rd;
        @(negedge clk);
        if (done) return;
        if (rst_n) begin
            check16("R7 outputs vs model", {12'h0, irq_out}, {12'h0, m_out});
            if (addr == 4'h4) begin
                exp_rd = m_mask;
                check16("R2 mask read vs model", rdata, exp_rd);
            end else if (addr == 4'hC) begin
                exp_rd = m_flags;
                check16("R3 flag read vs model", rdata, exp_rd);
            end else begin
                check16("R10 other read vs model", rdata, 16'h0);
            end
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick();
        we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic [15:0] exp, string tag);
        addr = a; we = 1'b0;
        tick();
        check16(tag, rdata, exp);
    endtask

    task automatic out_is(logic [3:0] exp, string tag);
        check16(tag, {12'h0, irq_out}, {12'h0, exp});
    endtask

    task automatic wait_n(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(4'h4, 16'hFFFF, "R1 mask after reset");
        rd(4'hC, 16'h0000, "R1 flags after reset");
        out_is(4'h0, "R1 outputs after reset");

        // R2 bring-up writes
        wr(4'h4, 16'h7FFE);
        rd(4'h4, 16'h7FFE, "R2 mask readback");
        wr(4'hC, 16'h0000);
        wr(4'h4, 16'h0000);
        rd(4'h4, 16'h0000, "R2 mask cleared");

        // R4 level sensing, two sources of group 0
        irq_n[3] = 1'b0; irq_n[5] = 1'b0;
        wait_n(5);
        rd(4'hC, 16'h0028, "R4 level flags set");
        out_is(4'b0001, "R7 group 0 raised");
        wr(4'hC, 16'h0000);
        rd(4'hC, 16'h0028, "R4 held-low flag survives clear");

        // R3 ones keep, zeros clear
        irq_n[3] = 1'b1; irq_n[5] = 1'b1;
        wait_n(4);
        rd(4'hC, 16'h0028, "R3 flags sticky after release");
        wr(4'hC, 16'hFFF7);
        rd(4'hC, 16'h0020, "R3 only zero bit cleared");
        out_is(4'b0001, "R7 group 0 still pending");
        wr(4'hC, 16'h0000);
        wait_n(2);
        rd(4'hC, 16'h0000, "R3 all flags cleared");
        out_is(4'b0000, "R7 outputs drop after clear");

        // R8 masked source latches but stays off the outputs
        wr(4'h4, 16'h0400);
        irq_n[10] = 1'b0;
        wait_n(5);
        rd(4'hC, 16'h0400, "R8 masked flag latched");
        out_is(4'b0000, "R8 masked output quiet");
        wr(4'h4, 16'h0000);
        wait_n(2);
        out_is(4'b0100, "R8 unmask raises group 2");
        irq_n[10] = 1'b1;
        wait_n(4);
        wr(4'hC, 16'h0000);
        wait_n(2);

        // R7 every level source against its group
        for (int i = 1; i <= 14; i++) begin
            irq_n[i] = 1'b0;
            wait_n(5);
            out_is(grp_of(i), $sformatf("R7 source %0d group", i));
            irq_n[i] = 1'b1;
            wait_n(4);
            wr(4'hC, ~(16'h1 << i));
            wait_n(2);
            out_is(4'b0000, $sformatf("R7 source %0d cleared", i));
        end

        // R6 source 0 never latches
        irq_n[0] = 1'b0;
        wait_n(5);
        rd(4'hC, 16'h0000, "R6 bit 0 stays clear");
        out_is(4'b0000, "R6 no output from bit 0");
        irq_n[0] = 1'b1;
        wait_n(3);

        // R9 / R5 falling-edge source
        irq_n[15] = 1'b0;
        wait_n(5);
        rd(4'hC, 16'h8000, "R5 edge flag set");
        out_is(4'b0000, "R9 edge source drives no output");
        wr(4'hC, 16'h0000);
        wait_n(3);
        rd(4'hC, 16'h0000, "R5 held low does not relatch");
        irq_n[15] = 1'b1;
        wait_n(4);
        rd(4'hC, 16'h0000, "R5 rising line sets nothing");
        irq_n[15] = 1'b0;
        tick();
        tick();
        wr(4'hC, 16'h0000);
        rd(4'hC, 16'h8000, "R5 edge beats same-cycle clear");
        irq_n[15] = 1'b1;
        wait_n(4);
        wr(4'hC, 16'h0000);

        // R10 unmapped addresses
        wr(4'h4, 16'h1234);
        irq_n[6] = 1'b0;
        wait_n(5);
        irq_n[6] = 1'b1;
        wait_n(4);
        wr(4'h2, 16'h0000);
        wr(4'h8, 16'hFFFF);
        rd(4'h4, 16'h1234, "R10 mask untouched by stray writes");
        rd(4'hC, 16'h0040, "R10 flags untouched by stray writes");
        rd(4'h2, 16'h0000, "R10 unmapped read is zero");
        out_is(4'b0010, "R7 group 1 from source 6");

        wait_n(2);
        finish_run();
    end

endmodule